// File: doc/BRIEF.md
# DMA Channel Control and Request Front End

This block holds the control word of a single DMA channel and converts transfer requests into clean single-cycle pulses for a data mover. Software writes the control word through a plain write port and reads it back through a combinational read port. The word carries the two completion-interrupt enables, an endianness flag, a snoop-use flag, the request-source select and two external-request qualifiers. It also carries a start bit that arms the channel.

Once armed, the channel turns requests into a one-cycle `xfer_req` pulse with a matching one-cycle active-low `ack_n`. In software mode the requests come from a strobe. In external mode they come from an asynchronous active-low line, which is detected either by level or by falling edge after a synchronizer. A done or abort input returns the channel to idle and raises the matching completion interrupt for one cycle when its enable is set. The endianness and snoop flags are only stored and brought out as outputs.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the read port returns 0x0000000E, which means normal-completion enable (bit 1), abnormal-completion enable (bit 2) and big-endian (bit 3) are 1 and every other bit is 0. After reset `armed` is 0, `xfer_req` is 0, `ack_n` is 1 and both interrupts are 0.
- R2: The output `big_endian` follows control bit 3 and `snoop_en` follows control bit 7, each updating in the cycle after the write.
- R3: Writing 1 to bit 0 (start) raises `armed` in the cycle after the write. Writing 0 to bit 0 leaves `armed` unchanged. Bit 0 always reads as 0.
- R4: Bits 31:8 read as 0 whatever is written to them. Bit 5 (polarity) is forced to 0 on every write and always reads 0.
- R5: When armed in software mode (bit 4 = 0), each cycle in which `sw_req` is high produces `xfer_req` = 1 and `ack_n` = 0 in the following cycle only.
- R6: In software mode `ext_req_n` has no effect, and in external mode (bit 4 = 1) `sw_req` has no effect.
- R7: While `armed` is 0, no request produces `xfer_req` or a low `ack_n`.
- R8: `xfer_done` while armed clears `armed` in the next cycle and pulses `irq_done` for one cycle if bit 1 is set.
- R9: In external level mode (bit 4 = 1, bit 6 = 1), `xfer_req` is high in every cycle whose synchronized sample of `ext_req_n` is low. It starts three cycles after the line goes low and continues for as long as the line stays low.
- R10: In external edge mode (bit 4 = 1, bit 6 = 0), each falling edge of `ext_req_n` yields exactly one `xfer_req` pulse three cycles later, however long the line then stays low.
- R11: `xfer_abort` while armed clears `armed` and pulses `irq_abort` for one cycle if bit 2 is set. When the matching enable bit is 0, neither done nor abort raises its interrupt.
- R12: A start write in the same cycle as `xfer_done` on an armed channel leaves the channel idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| sw_req | input | 1 | Software transfer request strobe |
| ext_req_n | input | 1 | Asynchronous active-low external request line |
| xfer_done | input | 1 | Normal completion from the data mover |
| xfer_abort | input | 1 | Abnormal completion from the data mover |
| armed | output | 1 | Channel waiting for or serving requests |
| xfer_req | output | 1 | One-cycle transfer request pulse |
| ack_n | output | 1 | Active-low acknowledge, one cycle |
| irq_done | output | 1 | Normal completion interrupt pulse |
| irq_abort | output | 1 | Abnormal completion interrupt pulse |
| big_endian | output | 1 | Stored endianness flag |
| snoop_en | output | 1 | Stored snoop-use flag |

## Verification
Register writes, `armed`, both interrupts and the software request path all show their result one cycle after the stimulus. The bench drives each stimulus on a falling clock edge and samples at the next falling edge. The external line passes through two synchronizer flops and an output register, so its effects are sampled at the third falling edge after the line changes. The bench also samples the cycles just before and after that point to catch extra or early pulses. Edge mode is checked by counting the pulses over a long low period, and level mode by sampling several consecutive cycles.

// File: rtl/dmachc_pkg.sv
// Shared control word layout for the DMA channel control block.
// Assumes a control word of at least eight bits.
package dmachc_pkg;
    localparam int BIT_START  = 0;
    localparam int BIT_NIE    = 1;
    localparam int BIT_AIE    = 2;
    localparam int BIT_BIGEND = 3;
    localparam int BIT_EXTMOD = 4;
    localparam int BIT_POL    = 5;
    localparam int BIT_LEVEL  = 6;
    localparam int BIT_SNOOP  = 7;
    localparam int USED_BITS  = 8;

    typedef struct packed {
        logic snoop;
        logic level;
        logic pol;
        logic ext_mode;
        logic big_end;
        logic abt_ie;
        logic done_ie;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{snoop: 1'b0, level: 1'b0, pol: 1'b0,
                                        ext_mode: 1'b0, big_end: 1'b1,
                                        abt_ie: 1'b1, done_ie: 1'b1};
endpackage

// File: rtl/dmachc_cfg_reg.sv
// Control word register. Stores the mode and enable fields, turns a
// write of 1 to the start bit into a one-cycle start pulse, and forces
// the polarity field to 0. Assumes wr_en is a single-cycle strobe.
module dmachc_cfg_reg
    import dmachc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output chan_cfg_t         cfg,
    output logic              start_pulse
);
    localparam int RSV_W = DATA_W - USED_BITS;

    chan_cfg_t cfg_q;
    logic      rsv_unused;

    assign rsv_unused = ^wr_data[DATA_W-1:USED_BITS];

    // Store the writable fields; the polarity field only ever holds 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q.done_ie  <= wr_data[BIT_NIE];
            cfg_q.abt_ie   <= wr_data[BIT_AIE];
            cfg_q.big_end  <= wr_data[BIT_BIGEND];
            cfg_q.ext_mode <= wr_data[BIT_EXTMOD];
            cfg_q.pol      <= 1'b0;
            cfg_q.level    <= wr_data[BIT_LEVEL];
            cfg_q.snoop    <= wr_data[BIT_SNOOP];
        end
    end

    // Start acts on a written 1 only.
    assign start_pulse = wr_en & wr_data[BIT_START];

    // Assemble the read value; start and reserved bits read as 0.
    always_comb begin
        rd_data                = '0;
        rd_data[BIT_NIE]       = cfg_q.done_ie;
        rd_data[BIT_AIE]       = cfg_q.abt_ie;
        rd_data[BIT_BIGEND]    = cfg_q.big_end;
        rd_data[BIT_EXTMOD]    = cfg_q.ext_mode;
        rd_data[BIT_POL]       = cfg_q.pol;
        rd_data[BIT_LEVEL]     = cfg_q.level;
        rd_data[BIT_SNOOP]     = cfg_q.snoop;
        rd_data[DATA_W-1:USED_BITS] = {RSV_W{1'b0}};
    end

    assign cfg = cfg_q;

    // R4: an attempt to set polarity never shows up on the read port.
    p_pol_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_POL]) |=> !rd_data[BIT_POL]);
endmodule

// File: rtl/dmachc_req_det.sv
// Request detector. Synchronizes the asynchronous external line and
// selects software, external level or external edge detection. The
// polarity and level fields matter only in external mode. Assumes
// SYNC_STAGES >= 2.
module dmachc_req_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic level_mode,
    input  logic pol,
    input  logic sw_req,
    input  logic ext_req_n,
    output logic req_hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   line_s;
    logic                   line_act;
    logic                   line_edge;

    // Synchronizer chain; idle level of the line is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_req_n};
    end

    assign line_s = sync_q[SYNC_STAGES-1];

    // Previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= line_s;
    end

    // Active level and active transition of the synchronized line.
    always_comb begin
        line_act  = pol ? line_s : ~line_s;
        line_edge = pol ? (~prev_q & line_s) : (prev_q & ~line_s);
    end

    // Source select: software strobe or qualified external line.
    always_comb begin
        if (!ext_mode)      req_hit = sw_req;
        else if (level_mode) req_hit = line_act;
        else                req_hit = line_edge;
    end

    // R10: an edge request never repeats in the following cycle.
    p_edge_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && !level_mode && !pol && prev_q && !line_s) |=> !(prev_q && !line_s));
endmodule

// File: rtl/dmachc_seq.sv
// Channel sequencer. Holds the armed state, issues one-cycle request
// and acknowledge pulses, and raises completion interrupts gated by
// their enables. Completion on an armed channel takes priority over a
// start in the same cycle.
module dmachc_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start_pulse,
    input  logic req_hit,
    input  logic done,
    input  logic abort,
    input  logic done_ie,
    input  logic abt_ie,
    output logic armed,
    output logic xfer_req,
    output logic ack_n,
    output logic irq_done,
    output logic irq_abort
);
    logic finish;

    assign finish = armed & (done | abort);

    // Armed state: completion clears, start sets.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed <= 1'b0;
        else if (finish)      armed <= 1'b0;
        else if (start_pulse) armed <= 1'b1;
    end

    // Request pulse to the data mover.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_req <= 1'b0;
        else        xfer_req <= armed & req_hit;
    end

    // Active-low acknowledge on the request line side.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_n <= 1'b1;
        else        ack_n <= ~(armed & req_hit);
    end

    // Completion interrupts, each gated by its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_done  <= 1'b0;
            irq_abort <= 1'b0;
        end else begin
            irq_done  <= armed & done & done_ie;
            irq_abort <= armed & abort & abt_ie;
        end
    end

    // R7: a request pulse needs the channel armed in the cycle before.
    p_req_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> $past(armed));
    // R5: request and acknowledge appear together.
    p_ack_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req == !ack_n);
    // R8: done on an armed channel returns it to idle.
    p_done_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && done) |=> !armed);
    // R11: abort on an armed channel returns it to idle.
    p_abort_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && abort) |=> !armed);
    // R8: the done interrupt lasts a single cycle.
    p_irq_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);
endmodule

// File: rtl/dma_chan_ctrl.sv
// DMA channel control top. Joins the control register, the request
// detector and the sequencer, and exports the stored endianness and
// snoop flags. Assumes a single clock domain except ext_req_n.
module dma_chan_ctrl
    import dmachc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sw_req,
    input  logic              ext_req_n,
    input  logic              xfer_done,
    input  logic              xfer_abort,
    output logic              armed,
    output logic              xfer_req,
    output logic              ack_n,
    output logic              irq_done,
    output logic              irq_abort,
    output logic              big_endian,
    output logic              snoop_en
);
    chan_cfg_t cfg;
    logic      start_pulse;
    logic      req_hit;

    dmachc_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .cfg         (cfg),
        .start_pulse (start_pulse)
    );

    dmachc_req_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_mode   (cfg.ext_mode),
        .level_mode (cfg.level),
        .pol        (cfg.pol),
        .sw_req     (sw_req),
        .ext_req_n  (ext_req_n),
        .req_hit    (req_hit)
    );

    dmachc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .req_hit     (req_hit),
        .done        (xfer_done),
        .abort       (xfer_abort),
        .done_ie     (cfg.done_ie),
        .abt_ie      (cfg.abt_ie),
        .armed       (armed),
        .xfer_req    (xfer_req),
        .ack_n       (ack_n),
        .irq_done    (irq_done),
        .irq_abort   (irq_abort)
    );

    // Stored flags exported for the data path.
    assign big_endian = cfg.big_end;
    assign snoop_en   = cfg.snoop;
endmodule

// File: tb/dma_chan_ctrl_bench.sv
module dma_chan_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        sw_req, ext_req_n, xfer_done, xfer_abort;
    logic        armed, xfer_req, ack_n, irq_done, irq_abort, big_endian, snoop_en;

    int checks = 0;
    int fails  = 0;
    bit over   = 0;

    always #5 clk = ~clk;

    dma_chan_ctrl u_dma_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sw_req(sw_req), .ext_req_n(ext_req_n),
        .xfer_done(xfer_done), .xfer_abort(xfer_abort), .armed(armed),
        .xfer_req(xfer_req), .ack_n(ack_n), .irq_done(irq_done),
        .irq_abort(irq_abort), .big_endian(big_endian), .snoop_en(snoop_en)
    );

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write(logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        check("R1 read", rd_data, 32'h0000_000E);
        check("R1 armed", armed, 0);
        check("R1 req", xfer_req, 0);
        check("R1 ack_n", ack_n, 1);
        check("R1 irq", {irq_done, irq_abort}, 0);
        check("R2 big_endian", big_endian, 1);
        check("R2 snoop", snoop_en, 0);
    endtask

    task automatic t_write_fields();
        write(32'hFFFF_FF21 | 32'h80);
        check("R4 read", rd_data, 32'h0000_0080);
        check("R3 armed", armed, 1);
        check("R2 snoop", snoop_en, 1);
        check("R2 big_endian", big_endian, 0);
        write(32'h0000_000E);
        check("R3 zero write keeps armed", armed, 1);
        check("R3 start reads 0", rd_data[0], 0);
    endtask

    task automatic t_sw_req();
        sw_req = 1'b1; step(); sw_req = 1'b0;
        check("R5 req", xfer_req, 1);
        check("R5 ack_n", ack_n, 0);
        step();
        check("R5 req ends", xfer_req, 0);
        check("R5 ack_n ends", ack_n, 1);
        ext_req_n = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin step(); if (xfer_req) seen++; end
            check("R6 ext ignored in sw mode", seen, 0);
        end
        ext_req_n = 1'b1; step(3);
    endtask

    task automatic t_done();
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
        check("R8 armed cleared", armed, 0);
        check("R8 irq_done", irq_done, 1);
        step();
        check("R8 irq_done one cycle", irq_done, 0);
        sw_req = 1'b1; step(); sw_req = 1'b0;
        check("R7 idle req", xfer_req, 0);
        check("R7 idle ack_n", ack_n, 1);
    endtask

    task automatic t_level();
        write(32'h0000_005F);   // ext, level, enables, big-endian, start
        check("R9 armed", armed, 1);
        ext_req_n = 1'b0;
        step(2);
        check("R9 not yet", xfer_req, 0);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R9 held low", xfer_req, 1);
        end
        ext_req_n = 1'b1;
        step(4);
        check("R9 released", xfer_req, 0);
        sw_req = 1'b1; step(); sw_req = 1'b0;
        check("R6 sw ignored in ext mode", xfer_req, 0);
    endtask

    task automatic t_edge();
        write(32'h0000_001F);   // ext, edge mode, enables, big-endian, start
        ext_req_n = 1'b0;
        step(2);
        check("R10 not yet", xfer_req, 0);
        step();
        check("R10 pulse", xfer_req, 1);
        begin
            int seen = 0;
            for (int i = 0; i < 8; i++) begin step(); if (xfer_req) seen++; end
            check("R10 single pulse", seen, 0);
        end
        ext_req_n = 1'b1; step(3);
        ext_req_n = 1'b0; step(3);
        check("R10 second edge", xfer_req, 1);
        ext_req_n = 1'b1; step(3);
    endtask

    task automatic t_abort();
        xfer_abort = 1'b1; step(); xfer_abort = 1'b0;
        check("R11 armed cleared", armed, 0);
        check("R11 irq_abort", irq_abort, 1);
        write(32'h0000_0009);   // both enables off, start
        xfer_abort = 1'b1; step(); xfer_abort = 1'b0;
        check("R11 abort masked", irq_abort, 0);
        write(32'h0000_0009);
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
        check("R11 done masked", irq_done, 0);
        check("R11 idle", armed, 0);
    endtask

    task automatic t_priority();
        write(32'h0000_000F);
        wr_en = 1'b1; wr_data = 32'h0000_000F; xfer_done = 1'b1;
        step();
        wr_en = 1'b0; xfer_done = 1'b0;
        check("R12 done wins", armed, 0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 0; wr_data = '0; sw_req = 0;
        ext_req_n = 1'b1; xfer_done = 0; xfer_abort = 0;
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_write_fields();
        t_sw_req();
        t_done();
        t_level();
        t_edge();
        t_abort();
        t_priority();
        if (!over) begin
            over = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!over) begin
            over = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule